// File: doc/BRIEF.md
# Programmable One-Shot Pulse Timer

The block turns each qualifying edge on an asynchronous trigger input into one output pulse. The trigger is brought into the clock domain by a two-flop synchronizer. A third flop detects the edge. An accepted edge drives the output to its active level and starts a count of master ticks. The output returns to idle once the count reaches the length chosen by a 3-bit divide select. That length is 8 raised to the select value, so it runs from 1 tick up to 2^21 ticks.

The master oscillator itself is not part of the block. Its ticks arrive as a one-cycle enable, and a halt flag stands for an oscillator that has stopped. Two elaboration parameters fix the behaviour of the instance: which trigger edge counts, and whether an edge during an active pulse restarts the count or is ignored. A polarity input sets the idle level of the output. A ready input gates triggers, for example while the system is still starting up.

Top module: `oneshot_timer`

## Requirements
- R1: While reset is asserted and after it is released, with no trigger, the output sits at its idle level, which equals `pol`.
- R2: With `div_sel` = k held steady and a tick on every cycle, an accepted edge keeps the output active for exactly 8^k cycles (k = 0..7 gives 1, 8, 64, 512, 4096, 32768, 262144, 2097152 ticks).
- R3: With `FALL_EDGE` = 0, only a 0-to-1 change of `trig` starts a pulse. With `FALL_EDGE` = 1, only a 1-to-0 change does. The opposite change starts nothing.
- R4: With `RETRIG` = 0, a qualifying edge that arrives while the output is active is ignored, and the pulse keeps its width.
- R5: With `RETRIG` = 0, after a pulse ends, edges are ignored until one tick that is not halted has been seen. After that tick, an edge starts a pulse again.
- R6: With `RETRIG` = 1, an edge accepted during an active pulse restarts the count. The output stays active until 8^k ticks after the last accepted edge.
- R7: The active level of the output is the inverse of `pol`.
- R8: While `halt` is high, ticks are not counted. A pulse can still start, but it does not end. Once `halt` falls, the pulse ends after its remaining ticks.
- R9: While `ready` is low, every trigger edge is ignored.
- R10: A pulse ends on the first tick at which its count reaches the ratio selected by `div_sel` at that moment. If the select drops to a ratio the count has already passed, the pulse ends on the next tick.
- R11: A trigger change that is stable before a clock edge makes the output active after the third rising clock edge.
- R12: With `RETRIG` = 1, an edge accepted in the same cycle as the pulse's final tick takes priority. The output stays active with no idle gap, and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Master-tick enable, one cycle per oscillator period |
| halt | input | 1 | Oscillator stopped; ticks are not counted while high |
| ready | input | 1 | Trigger edges are accepted only while high |
| trig | input | 1 | Asynchronous trigger input |
| div_sel | input | 3 | Pulse-length select; length is 8^div_sel ticks |
| pol | input | 1 | Idle level of the output |
| pulse_out | output | 1 | Pulse output with polarity applied |

## Verification
In retriggerable mode, a new accepted edge and the final tick of a running pulse can land in the same cycle. The bench provokes this with an 8-tick pulse. It drops the trigger just after the first edge and raises it again at the offset that places the second acceptance on the eighth tick. The result is judged by the measured active run: 16 unbroken cycles show that the restart won, while an 8-cycle run shows that the end won. The non-retriggerable lockout is checked in a similar way. Ticks are stopped right after a pulse ends, and an edge applied then must produce nothing.

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter bit FALL_EDGE = 1'b0,
  parameter bit RETRIG    = 1'b1,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             halt,
  input  logic             ready,
  input  logic             trig,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             pol,
  output logic             pulse_out
);
  localparam int MAX_EXP = 3 * ((1 << SEL_W) - 1);
  localparam int CNT_W   = MAX_EXP + 1;

  logic [2:0]       sync;
  logic             active, lock;
  logic [CNT_W-1:0] cnt, limit, cnt_nxt;
  logic             hit, run, accept, done;

  assign hit     = FALL_EDGE ? (~sync[1] & sync[2]) : (sync[1] & ~sync[2]);
  assign run     = tick & ~halt;
  assign accept  = ready & hit & (RETRIG ? 1'b1 : (~active & ~lock));
  assign limit   = CNT_W'(1) << (3 * div_sel);
  assign cnt_nxt = cnt + 1'b1;
  assign done    = active & run & (cnt_nxt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= {3{FALL_EDGE}};
    else        sync <= {sync[1:0], trig};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (accept) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (done) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active && run) begin
      cnt    <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      lock <= 1'b0;
    else if (!RETRIG && done)        lock <= 1'b1;
    else if (run)                    lock <= 1'b0;
  end

  assign pulse_out = active ^ pol;

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && halt |=> active);

  // R9
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !ready |=> !active);

  // R4
  nr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !RETRIG && active && !run |=> $stable(cnt));

  // R5
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !RETRIG && lock && !run |=> !active);

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    RETRIG && accept |=> active && cnt == '0);
endmodule

// File: tb/oneshot_timer_test.sv
module oneshot_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1, halt = 1'b0, ready = 1'b1, pol = 1'b0;
  logic trig_a = 1'b0, trig_b = 1'b1;
  logic [2:0] div_sel = 3'd0;
  logic out_a, out_b;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  oneshot_timer #(.FALL_EDGE(1'b0), .RETRIG(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt), .ready(ready),
    .trig(trig_a), .div_sel(div_sel), .pol(pol), .pulse_out(out_a));

  oneshot_timer #(.FALL_EDGE(1'b1), .RETRIG(1'b0)) uut2 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt), .ready(ready),
    .trig(trig_b), .div_sel(div_sel), .pol(pol), .pulse_out(out_b));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit act(input int which);
    return ((which == 0) ? out_a : out_b) ^ pol;
  endfunction

  task automatic edge_a();
    @(negedge clk) trig_a = 1'b0;
    repeat (3) @(negedge clk);
    trig_a = 1'b1;
  endtask

  task automatic edge_b();
    @(negedge clk) trig_b = 1'b1;
    repeat (3) @(negedge clk);
    trig_b = 1'b0;
  endtask

  task automatic pulse_width(input int which, input int maxc, output int w);
    w = 0;
    for (int i = 0; i < 20; i++) begin
      if (act(which)) break;
      @(negedge clk);
    end
    while (act(which) && w < maxc) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic idle_for(input int which, input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (act(which)) seen = 1'b1;
    end
    chk(!seen, req, seen, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_a == 1'b0 && out_b == 1'b0, "R1 in reset", {out_a, out_b}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_a == 1'b0 && out_b == 1'b0, "R1 after reset", {out_a, out_b}, 0);
  endtask

  task automatic t_widths();
    int w;
    for (int k = 0; k <= 4; k++) begin
      div_sel = 3'(k);
      edge_a();
      pulse_width(0, 5000, w);
      chk(w == (1 << (3 * k)), $sformatf("R2 width code %0d", k), w, 1 << (3 * k));
    end
  endtask

  task automatic t_sync();
    int w;
    div_sel = 3'd0;
    @(negedge clk) trig_a = 1'b0;
    repeat (4) @(negedge clk);
    trig_a = 1'b1;
    @(negedge clk);
    chk(!act(0), "R11 idle after 1 edge", act(0), 0);
    @(negedge clk);
    chk(!act(0), "R11 idle after 2 edges", act(0), 0);
    @(negedge clk);
    chk(act(0), "R11 active after 3 edges", act(0), 1);
    pulse_width(0, 100, w);
  endtask

  task automatic t_edge_sense();
    int w;
    div_sel = 3'd1;
    edge_b();
    pulse_width(1, 100, w);
    chk(w == 8, "R3 falling edge fires falling-mode unit", w, 8);
    @(negedge clk) trig_b = 1'b1;
    idle_for(1, 10, "R3 rising edge ignored by falling-mode unit");
    @(negedge clk) trig_a = 1'b0;
    idle_for(0, 10, "R3 falling edge ignored by rising-mode unit");
  endtask

  task automatic t_polarity();
    pol = 1'b1;
    div_sel = 3'd1;
    repeat (2) @(negedge clk);
    chk(out_a == 1'b1, "R7 idle equals pol", out_a, 1);
    edge_a();
    repeat (3) @(negedge clk);
    chk(out_a == 1'b0, "R7 active is inverse of pol", out_a, 0);
    repeat (10) @(negedge clk);
    chk(out_a == 1'b1, "R7 back to idle", out_a, 1);
    pol = 1'b0;
  endtask

  task automatic t_nonretrig();
    int w;
    div_sel = 3'd1;
    edge_b();
    fork
      pulse_width(1, 100, w);
      begin
        repeat (4) @(negedge clk);
        trig_b = 1'b1;
        repeat (2) @(negedge clk);
        trig_b = 1'b0;
      end
    join
    chk(w == 8, "R4 edge during pulse ignored", w, 8);
    idle_for(1, 10, "R4 no late pulse");
  endtask

  task automatic t_rearm();
    int w;
    div_sel = 3'd0;
    edge_b();
    for (int i = 0; i < 10; i++) begin
      if (act(1)) break;
      @(negedge clk);
    end
    @(negedge clk);
    tick = 1'b0;
    chk(!act(1), "R5 pulse ended", act(1), 0);
    edge_b();
    idle_for(1, 10, "R5 edge in rearm window ignored");
    tick = 1'b1;
    repeat (2) @(negedge clk);
    edge_b();
    pulse_width(1, 100, w);
    chk(w == 1, "R5 edge accepted after rearm tick", w, 1);
  endtask

  task automatic t_retrig(input int k, input int exp, input string req);
    int w;
    div_sel = 3'd1;
    edge_a();
    fork
      pulse_width(0, 200, w);
      begin
        @(negedge clk) trig_a = 1'b0;
        repeat (k - 1) @(negedge clk);
        trig_a = 1'b1;
      end
    join
    chk(w == exp, req, w, exp);
  endtask

  task automatic t_halt();
    int w;
    div_sel = 3'd1;
    halt = 1'b1;
    edge_a();
    repeat (3) @(negedge clk);
    chk(act(0), "R8 pulse starts while halted", act(0), 1);
    repeat (20) @(negedge clk);
    chk(act(0), "R8 pulse held while halted", act(0), 1);
    halt = 1'b0;
    pulse_width(0, 100, w);
    chk(w == 8, "R8 remaining width after resume", w, 8);
  endtask

  task automatic t_ready();
    div_sel = 3'd1;
    ready = 1'b0;
    edge_a();
    idle_for(0, 12, "R9 rising unit ignores trigger when not ready");
    edge_b();
    idle_for(1, 12, "R9 falling unit ignores trigger when not ready");
    ready = 1'b1;
  endtask

  task automatic t_div_change();
    int w;
    div_sel = 3'd2;
    edge_a();
    fork
      pulse_width(0, 200, w);
      begin
        repeat (14) @(negedge clk);
        div_sel = 3'd1;
      end
    join
    chk(w == 12, "R10 width after select drop", w, 12);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_widths();
    t_sync();
    t_edge_sense();
    t_polarity();
    t_nonretrig();
    t_rearm();
    t_retrig(5, 13, "R6 retrigger extends pulse");
    repeat (4) @(negedge clk);
    t_retrig(8, 16, "R12 retrigger on final tick keeps pulse");
    repeat (4) @(negedge clk);
    t_halt();
    t_ready();
    t_div_change();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule